// File: doc/BRIEF.md
# Fractional-N PLL Reprogramming Sequencer

This block is a hardware state machine that takes a fractional-N PLL through a safe change of its settings. On a start pulse it captures a target setting: integer multiplier, fractional numerator and denominator, reference pre-divider, post-divider, and a flag that selects fractional or integer operation. It then issues a fixed series of writes through a one-cycle register-write port. The series first parks the PLL: hand control to the registers, gate the output, power down and leave bypass. It then loads the dividers, waits a settle interval, powers up, waits a bounded time for lock and only then opens the output gate. The caller sees a done pulse, or an error pulse if lock never arrives.

Two shorter commands share the same port. Prepare raises a powered-down PLL through bypass and does nothing if power is already on. Unprepare only removes power. The PLL's own status (lock bit and numerator read-back) arrives on input pins. The block keeps a shadow copy of the control register so that each control write changes exactly one bit.

Top module: `fracpll_reseq`

## Requirements
- R1: After reset, busy, doneO, errO, regWrEn and numMismatch are all low, and the control shadow holds CTRL_INIT (hardware-control select, bit 16, set).
- R2: A start command writes the control register (address 0) four times in order, each write being the previous value with one more bit cleared: hardware-control select (bit 16), then output enable (bit 1), then power-up (bit 0), then bypass (bit 2). The next write goes to the divider register.
- R3: The divider register (address 1) carries the multiplier in bits 24:16, the reference divider in bits 15:13 and the post divider in bits 7:0, with all other bits zero.
- R4: In fractional mode the divider write is followed by the denominator write (address 2, value in bits 29:0) and then the numerator write (address 3, value in bits 31:2). In integer mode both of these writes are skipped.
- R5: The control write that sets power-up comes at least SETTLE_US*CYC_PER_US cycles after the last divider-group write.
- R6: After power-up, a high statusLock leads to one control write that sets output enable, then a done pulse. If lock has not been seen within LOCK_US*CYC_PER_US cycles of the power-up write, an error pulse is raised and output enable is not written.
- R7: Output enable is never switched on by a write unless power-up is set in that same write and lock was observed.
- R8: In fractional mode, when lock is seen, numMismatch is set if statusNum differs from the requested numerator. The flag then holds until the next accepted command clears it. In integer mode the flag stays low.
- R9: Prepare with power already on gives a done pulse and makes no write. Otherwise it sets bypass, then power-up, waits for lock, sets output enable, clears bypass and then pulses done.
- R10: Unprepare makes exactly one control write, which clears only the power-up bit, then pulses done.
- R11: busy is high from the cycle after a command is accepted until done or error. Commands and configuration changes that arrive while busy are ignored. When requests arrive together, start wins over prepare, and prepare wins over unprepare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Reprogram command pulse |
| prepReq | input | 1 | Prepare command pulse |
| unprepReq | input | 1 | Unprepare command pulse |
| fracMode | input | 1 | 1 selects fractional operation for a reprogram |
| cfgMul | input | 9 | Integer multiplier |
| cfgRef | input | 3 | Reference pre-divider code |
| cfgPost | input | 8 | Post-divider code |
| cfgNum | input | 30 | Fractional numerator |
| cfgDen | input | 30 | Fractional denominator |
| statusLock | input | 1 | PLL lock indication |
| statusNum | input | 30 | Numerator read back from the PLL status |
| regWrEn | output | 1 | Register write strobe, one cycle per write |
| regWrAddr | output | 2 | Register select: 0 control, 1 divider, 2 denominator, 3 numerator |
| regWrData | output | 32 | Register write value |
| busy | output | 1 | Sequence in progress |
| doneO | output | 1 | One-cycle completion pulse |
| errO | output | 1 | One-cycle lock-timeout pulse |
| numMismatch | output | 1 | Numerator read-back differed at lock |

## Verification
Some properties are checked on every cycle: output enable is never turned on without power and a lock seen two cycles earlier, the power-up write always comes at least the settle interval after the last divider write, a lock wait never runs past its bound, and an error comes only when the wait counter has reached that bound. The order and values of the writes, the packing of the divider fields, the skipping of the fractional writes in integer mode, command priority, the ignoring of commands while busy, and the mismatch flag are things only the bench's scenarios can show. The bench runs a sweep of configurations against a behavioural PLL model and compares the logged writes with a sequence it computes arithmetically.

// File: rtl/fracpll_reseq_pkg.sv
package fracpll_reseq_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned MUL_W    = 9;
  localparam int unsigned REF_W    = 3;
  localparam int unsigned POST_W   = 8;
  localparam int unsigned FRAC_W   = 30;

  localparam int unsigned BIT_HWSEL = 16;
  localparam int unsigned BIT_BYP   = 2;
  localparam int unsigned BIT_OUTEN = 1;
  localparam int unsigned BIT_PWR   = 0;

  localparam int unsigned DIV_MUL_LSB  = 16;
  localparam int unsigned DIV_REF_LSB  = 13;
  localparam int unsigned DIV_POST_LSB = 0;
  localparam int unsigned NUM_LSB      = 2;
  localparam int unsigned DEN_LSB      = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_DIV  = 2'd1,
    A_DEN  = 2'd2,
    A_NUM  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    CB_PWR,
    CB_OUTEN,
    CB_BYP,
    CB_HWSEL
  } ctrlBit_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_R_HWSEL,
    S_R_OUTOFF,
    S_R_PWROFF,
    S_R_BYPOFF,
    S_R_DIV,
    S_R_DEN,
    S_R_NUM,
    S_R_SETTLE,
    S_R_PWRON,
    S_R_LOCK,
    S_R_OUTON,
    S_P_BYPON,
    S_P_PWRON,
    S_P_LOCK,
    S_P_OUTON,
    S_P_BYPOFF,
    S_U_PWROFF,
    S_DONE,
    S_ERR
  } seqState_e;

  typedef struct packed {
    logic     wrCtrl;
    ctrlBit_e ctrlBit;
    logic     ctrlVal;
    logic     wrDiv;
    logic     wrDen;
    logic     wrNum;
    logic     latchCfg;
    logic     cntClr;
    logic     checkNum;
    logic     clrFlag;
  } seqStrobe_t;

endpackage

// File: rtl/fracpll_reseq_ctrl.sv
module fracpll_reseq_ctrl
  import fracpll_reseq_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SETTLE_CYC = 625,
  parameter int unsigned LOCK_CYC   = 25000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             prepReq,
  input  logic             unprepReq,
  input  logic             fracOn,
  input  logic             pwrOn,
  input  logic             lockHit,
  input  logic [CNT_W-1:0] cnt,
  output seqStrobe_t       stb,
  output logic             busy,
  output logic             doneO,
  output logic             errO
);

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_CYC - 1);

  seqState_e st, stN;

  always_comb begin
    stN         = st;
    stb         = '0;
    stb.ctrlBit = CB_PWR;
    stb.cntClr  = 1'b1;
    unique case (st)
      S_IDLE: begin
        if (startReq) begin
          stb.latchCfg = 1'b1;
          stb.clrFlag  = 1'b1;
          stN          = S_R_HWSEL;
        end else if (prepReq) begin
          stb.clrFlag = 1'b1;
          stN         = pwrOn ? S_DONE : S_P_BYPON;
        end else if (unprepReq) begin
          stb.clrFlag = 1'b1;
          stN         = S_U_PWROFF;
        end
      end
      S_R_HWSEL: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_HWSEL; stb.ctrlVal = 1'b0;
        stN = S_R_OUTOFF;
      end
      S_R_OUTOFF: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_OUTEN; stb.ctrlVal = 1'b0;
        stN = S_R_PWROFF;
      end
      S_R_PWROFF: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_PWR; stb.ctrlVal = 1'b0;
        stN = S_R_BYPOFF;
      end
      S_R_BYPOFF: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_BYP; stb.ctrlVal = 1'b0;
        stN = S_R_DIV;
      end
      S_R_DIV: begin
        stb.wrDiv = 1'b1;
        stN = fracOn ? S_R_DEN : S_R_SETTLE;
      end
      S_R_DEN: begin
        stb.wrDen = 1'b1;
        stN = S_R_NUM;
      end
      S_R_NUM: begin
        stb.wrNum = 1'b1;
        stN = S_R_SETTLE;
      end
      S_R_SETTLE: begin
        stb.cntClr = 1'b0;
        if (cnt == SETTLE_LAST) stN = S_R_PWRON;
      end
      S_R_PWRON: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_PWR; stb.ctrlVal = 1'b1;
        stN = S_R_LOCK;
      end
      S_R_LOCK: begin
        stb.cntClr = 1'b0;
        if (lockHit) begin
          stb.checkNum = fracOn;
          stN          = S_R_OUTON;
        end else if (cnt == LOCK_LAST) begin
          stN = S_ERR;
        end
      end
      S_R_OUTON: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_OUTEN; stb.ctrlVal = 1'b1;
        stN = S_DONE;
      end
      S_P_BYPON: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_BYP; stb.ctrlVal = 1'b1;
        stN = S_P_PWRON;
      end
      S_P_PWRON: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_PWR; stb.ctrlVal = 1'b1;
        stN = S_P_LOCK;
      end
      S_P_LOCK: begin
        stb.cntClr = 1'b0;
        if (lockHit)                stN = S_P_OUTON;
        else if (cnt == LOCK_LAST)  stN = S_ERR;
      end
      S_P_OUTON: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_OUTEN; stb.ctrlVal = 1'b1;
        stN = S_P_BYPOFF;
      end
      S_P_BYPOFF: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_BYP; stb.ctrlVal = 1'b0;
        stN = S_DONE;
      end
      S_U_PWROFF: begin
        stb.wrCtrl = 1'b1; stb.ctrlBit = CB_PWR; stb.ctrlVal = 1'b0;
        stN = S_DONE;
      end
      S_DONE:  stN = S_IDLE;
      S_ERR:   stN = S_IDLE;
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stN;
  end

  assign busy  = !(st inside {S_IDLE, S_DONE, S_ERR});
  assign doneO = (st == S_DONE);
  assign errO  = (st == S_ERR);

  AST_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq || prepReq || unprepReq))
    else $error("busy rose without a request"); // R11

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_R_LOCK || st == S_P_LOCK) |-> (cnt <= LOCK_LAST))
    else $error("lock wait ran past its bound"); // R6

  AST_ERR_AT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    errO |-> ($past(cnt) == LOCK_LAST))
    else $error("error raised before the lock window ended"); // R6

  AST_SETTLE_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_R_PWRON) |-> ($past(cnt) == SETTLE_LAST))
    else $error("power-up reached without full settle count"); // R5

endmodule

// File: rtl/fracpll_reseq_datapath.sv
module fracpll_reseq_datapath
  import fracpll_reseq_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SETTLE_CYC = 625,
  parameter logic [REG_W-1:0] CTRL_INIT = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              fracMode,
  input  logic [MUL_W-1:0]  cfgMul,
  input  logic [REF_W-1:0]  cfgRef,
  input  logic [POST_W-1:0] cfgPost,
  input  logic [FRAC_W-1:0] cfgNum,
  input  logic [FRAC_W-1:0] cfgDen,
  input  logic [FRAC_W-1:0] statusNum,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [REG_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  cnt,
  output logic              pwrOn,
  output logic              fracOn,
  output logic              numMismatch
);

  logic [REG_W-1:0]  ctrlQ, ctrlNext, divWord, denWord, numWord;
  logic [MUL_W-1:0]  mulQ;
  logic [REF_W-1:0]  refQ;
  logic [POST_W-1:0] postQ;
  logic [FRAC_W-1:0] numQ, denQ;
  regSel_e           addrQ;

  always_comb begin
    ctrlNext = ctrlQ;
    unique case (stb.ctrlBit)
      CB_PWR:   ctrlNext[BIT_PWR]   = stb.ctrlVal;
      CB_OUTEN: ctrlNext[BIT_OUTEN] = stb.ctrlVal;
      CB_BYP:   ctrlNext[BIT_BYP]   = stb.ctrlVal;
      CB_HWSEL: ctrlNext[BIT_HWSEL] = stb.ctrlVal;
      default:  ctrlNext = ctrlQ;
    endcase
  end

  always_comb begin
    divWord = '0;
    divWord[DIV_MUL_LSB  +: MUL_W]  = mulQ;
    divWord[DIV_REF_LSB  +: REF_W]  = refQ;
    divWord[DIV_POST_LSB +: POST_W] = postQ;
    denWord = '0;
    denWord[DEN_LSB +: FRAC_W] = denQ;
    numWord = '0;
    numWord[NUM_LSB +: FRAC_W] = numQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ       <= CTRL_INIT;
      regWrEn     <= 1'b0;
      addrQ       <= A_CTRL;
      regWrData   <= '0;
      cnt         <= '0;
      mulQ        <= '0;
      refQ        <= '0;
      postQ       <= '0;
      numQ        <= '0;
      denQ        <= '0;
      fracOn      <= 1'b0;
      numMismatch <= 1'b0;
    end else begin
      regWrEn <= stb.wrCtrl | stb.wrDiv | stb.wrDen | stb.wrNum;
      if (stb.wrCtrl) begin
        ctrlQ     <= ctrlNext;
        addrQ     <= A_CTRL;
        regWrData <= ctrlNext;
      end else if (stb.wrDiv) begin
        addrQ     <= A_DIV;
        regWrData <= divWord;
      end else if (stb.wrDen) begin
        addrQ     <= A_DEN;
        regWrData <= denWord;
      end else if (stb.wrNum) begin
        addrQ     <= A_NUM;
        regWrData <= numWord;
      end
      cnt <= stb.cntClr ? '0 : cnt + 1'b1;
      if (stb.latchCfg) begin
        mulQ   <= cfgMul;
        refQ   <= cfgRef;
        postQ  <= cfgPost;
        numQ   <= cfgNum;
        denQ   <= cfgDen;
        fracOn <= fracMode;
      end
      if (stb.clrFlag)       numMismatch <= 1'b0;
      else if (stb.checkNum) numMismatch <= (statusNum != numQ);
    end
  end

  assign regWrAddr = addrQ;
  assign pwrOn     = ctrlQ[BIT_PWR];

  // Assertion-side gap counter: cycles since the last divider-group write.
  localparam int unsigned GAP_W = CNT_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  logic [GAP_W-1:0] gapCnt;
  logic             gapArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      gapArmed <= 1'b0;
    end else begin
      if (regWrEn && regWrAddr != A_CTRL) begin
        gapCnt   <= '0;
        gapArmed <= 1'b1;
      end else begin
        if (gapCnt != GAP_MAX) gapCnt <= gapCnt + 1'b1;
        if (regWrEn) gapArmed <= 1'b0;
      end
    end
  end

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr == A_CTRL && regWrData[BIT_PWR] && gapArmed)
      |-> (gapCnt >= GAP_W'(SETTLE_CYC)))
    else $error("power-up written too soon after dividers"); // R5

endmodule

// File: rtl/fracpll_reseq.sv
module fracpll_reseq
  import fracpll_reseq_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 125,
  parameter int unsigned SETTLE_US  = 5,
  parameter int unsigned LOCK_US    = 200,
  parameter logic [31:0] CTRL_INIT  = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        prepReq,
  input  logic        unprepReq,
  input  logic        fracMode,
  input  logic [8:0]  cfgMul,
  input  logic [2:0]  cfgRef,
  input  logic [7:0]  cfgPost,
  input  logic [29:0] cfgNum,
  input  logic [29:0] cfgDen,
  input  logic        statusLock,
  input  logic [29:0] statusNum,
  output logic        regWrEn,
  output logic [1:0]  regWrAddr,
  output logic [31:0] regWrData,
  output logic        busy,
  output logic        doneO,
  output logic        errO,
  output logic        numMismatch
);

  localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int unsigned LOCK_CYC   = LOCK_US * CYC_PER_US;
  localparam int unsigned SPAN_MAX   = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W      = $clog2(SPAN_MAX) + 1;

  seqStrobe_t       stb;
  logic [CNT_W-1:0] cnt;
  logic             pwrOn;
  logic             fracOn;

  fracpll_reseq_ctrl #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .prepReq(prepReq), .unprepReq(unprepReq),
    .fracOn(fracOn), .pwrOn(pwrOn), .lockHit(statusLock), .cnt(cnt),
    .stb(stb), .busy(busy), .doneO(doneO), .errO(errO)
  );

  fracpll_reseq_datapath #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .CTRL_INIT(CTRL_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fracMode(fracMode), .cfgMul(cfgMul), .cfgRef(cfgRef), .cfgPost(cfgPost),
    .cfgNum(cfgNum), .cfgDen(cfgDen), .statusNum(statusNum),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .cnt(cnt), .pwrOn(pwrOn), .fracOn(fracOn), .numMismatch(numMismatch)
  );

  // Assertion-side copy of the last written output-enable bit.
  logic outenWas;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 outenWas <= CTRL_INIT[BIT_OUTEN];
    else if (regWrEn && regWrAddr == A_CTRL)   outenWas <= regWrData[BIT_OUTEN];
  end

  AST_OUTEN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr == A_CTRL && regWrData[BIT_OUTEN] && !outenWas)
      |-> (regWrData[BIT_PWR] && $past(statusLock, 2)))
    else $error("output enabled without power and lock"); // R7

endmodule

// File: tb/fracpll_reseq_bench.sv
module fracpll_reseq_bench;

  localparam int CYC_PER_US = 2;
  localparam int SETTLE_CYC = 5 * CYC_PER_US;
  localparam int LOCK_CYC   = 200 * CYC_PER_US;
  localparam int LOCK_DELAY = 6;
  localparam logic [31:0] INIT = 32'h0001_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, prepReq = 0, unprepReq = 0, fracMode = 0;
  logic [8:0]  cfgMul = 0;
  logic [2:0]  cfgRef = 0;
  logic [7:0]  cfgPost = 0;
  logic [29:0] cfgNum = 0, cfgDen = 0;
  logic        statusLock;
  logic [29:0] statusNum;
  logic        regWrEn, busy, doneO, errO, numMismatch;
  logic [1:0]  regWrAddr;
  logic [31:0] regWrData;

  always #4 clk = ~clk;

  fracpll_reseq #(.CYC_PER_US(CYC_PER_US), .SETTLE_US(5), .LOCK_US(200), .CTRL_INIT(INIT))
  u_fracpll_reseq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .prepReq(prepReq), .unprepReq(unprepReq),
    .fracMode(fracMode), .cfgMul(cfgMul), .cfgRef(cfgRef), .cfgPost(cfgPost),
    .cfgNum(cfgNum), .cfgDen(cfgDen), .statusLock(statusLock), .statusNum(statusNum),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .busy(busy), .doneO(doneO), .errO(errO), .numMismatch(numMismatch)
  );

  int errs = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PLL model and write log, both sampled away from the active edge.
  logic [31:0] mCtrl = INIT;
  logic [29:0] mNum = 0;
  logic        lockEnable = 1, corrupt = 0, lk = 0;
  int          lc = 0;
  int          logA [0:511];
  logic [31:0] logD [0:511];
  int          logC [0:511];
  int          logN = 0;

  assign statusLock = lk;
  assign statusNum  = corrupt ? (mNum ^ 30'h1) : mNum;

  always @(negedge clk) begin
    if (regWrEn && logN < 512) begin
      logA[logN] = int'(regWrAddr);
      logD[logN] = regWrData;
      logC[logN] = cyc;
      logN = logN + 1;
    end
    if (regWrEn && regWrAddr == 2'd0) mCtrl = regWrData;
    if (regWrEn && regWrAddr == 2'd3) mNum = regWrData[31:2];
    if (!mCtrl[0]) begin lk = 0; lc = 0; end
    else if (lockEnable) begin lc = lc + 1; lk = (lc >= LOCK_DELAY); end
  end

  int          expA [0:31];
  logic [31:0] expD [0:31];
  int          expR [0:31];
  int          expN;
  logic [31:0] bc = INIT;
  int          endCyc;
  logic        endDone, endErr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int a, input logic [31:0] d, input int r);
    expA[expN] = a; expD[expN] = d; expR[expN] = r; expN++;
  endtask

  task automatic issue(input int kind);
    @(negedge clk);
    startReq  = (kind == 0 || kind == 3);
    prepReq   = (kind == 1 || kind == 3);
    unprepReq = (kind == 2);
    @(negedge clk);
    startReq = 0; prepReq = 0; unprepReq = 0;
  endtask

  task automatic waitEnd();
    endDone = 0; endErr = 0;
    if (doneO || errO) begin
      endDone = doneO; endErr = errO; endCyc = cyc;
    end else begin
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (doneO || errO) begin
          endDone = doneO; endErr = errO; endCyc = cyc; break;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic compareLog(input int base, input string tag);
    check(logN - base == expN, "R2", {tag, " write count"}, logN - base, expN);
    for (int i = 0; i < expN; i++) begin
      if (base + i < logN) begin
        check(logA[base+i] == expA[i], $sformatf("R%0d", expR[i]),
              $sformatf("%s addr #%0d", tag, i), logA[base+i], expA[i]);
        check(logD[base+i] == expD[i], $sformatf("R%0d", expR[i]),
              $sformatf("%s data #%0d", tag, i), logD[base+i], expD[i]);
      end
    end
  endtask

  task automatic buildReprog(input logic [8:0] m, input logic [2:0] r, input logic [7:0] p,
                             input logic [29:0] n, input logic [29:0] d, input bit fr,
                             input bit lockOk);
    expN = 0;
    bc[16] = 0; push(0, bc, 2);   // R2 hardware-control select off
    bc[1]  = 0; push(0, bc, 2);   // R2 output gate off
    bc[0]  = 0; push(0, bc, 2);   // R2 power off
    bc[2]  = 0; push(0, bc, 2);   // R2 bypass off
    push(1, (32'(m) << 16) | (32'(r) << 13) | 32'(p), 3);   // R3
    if (fr) begin
      push(2, 32'(d), 4);         // R4 denominator
      push(3, 32'(n) << 2, 4);    // R4 numerator
    end
    bc[0] = 1; push(0, bc, 5);    // R5 power-up after settle
    if (lockOk) begin bc[1] = 1; push(0, bc, 6); end  // R6
  endtask

  task automatic doReprog(input logic [8:0] m, input logic [2:0] r, input logic [7:0] p,
                          input logic [29:0] n, input logic [29:0] d, input bit fr,
                          input bit lockOk, input bit bad, input string tag);
    int base, pwrIdx;
    cfgMul = m; cfgRef = r; cfgPost = p; cfgNum = n; cfgDen = d; fracMode = fr;
    lockEnable = lockOk; corrupt = bad;
    base = logN;
    buildReprog(m, r, p, n, d, fr, lockOk);
    issue(0);
    check(busy == 1'b1, "R11", {tag, " busy after accept"}, busy, 1);
    waitEnd();
    check(endDone == lockOk, "R6", {tag, " done"}, endDone, lockOk);
    check(endErr == !lockOk, "R6", {tag, " error"}, endErr, !lockOk);
    check(busy == 1'b0, "R11", {tag, " busy released"}, busy, 0);
    compareLog(base, tag);
    pwrIdx = base + (fr ? 7 : 5);
    if (pwrIdx < logN)
      check(logC[pwrIdx] - logC[pwrIdx-1] >= SETTLE_CYC, "R5", {tag, " settle gap"},
            logC[pwrIdx] - logC[pwrIdx-1], SETTLE_CYC);
    if (!lockOk && pwrIdx < logN)
      check(endCyc - logC[pwrIdx] >= LOCK_CYC && endCyc - logC[pwrIdx] <= LOCK_CYC + 2,
            "R6", {tag, " timeout span"}, endCyc - logC[pwrIdx], LOCK_CYC);
    if (lockOk)
      check(numMismatch == (fr && bad), "R8", {tag, " mismatch flag"}, numMismatch, fr && bad);
    lockEnable = 1; corrupt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !doneO && !errO && !regWrEn && !numMismatch, "R1", "outputs in reset",
          {busy, doneO, errO, regWrEn, numMismatch}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(!busy && !regWrEn && logN == 0, "R1", "idle after reset", logN, 0);

    // Configuration sweep (R2 R3 R4 R5 R6 R8)
    doReprog(9'h1FF, 3'd7, 8'hFF, 30'h2AAA_AAAA, 30'h3FFF_FFFF, 1, 1, 0, "sweep0");
    doReprog(9'h0A5, 3'd0, 8'h0C, 30'h0000_0019, 30'h0000_0064, 1, 1, 0, "sweep1");
    doReprog(9'h001, 3'd3, 8'h01, 30'h1555_5555, 30'h0000_0001, 0, 1, 0, "sweep2");
    doReprog(9'h100, 3'd5, 8'h80, 30'h0000_0000, 30'h0000_03E8, 1, 1, 0, "sweep3");
    doReprog(9'h0C8, 3'd1, 8'h06, 30'h0000_0248, 30'h0000_03E8, 0, 1, 0, "sweep4");
    // R8 mismatch set, then cleared by next command; integer mode ignores it
    doReprog(9'h0AD, 3'd1, 8'h04, 30'h0000_0019, 30'h0000_0064, 1, 1, 1, "mism");
    doReprog(9'h0AD, 3'd1, 8'h04, 30'h0000_0019, 30'h0000_0064, 0, 1, 1, "intmism");
    doReprog(9'h0AD, 3'd1, 8'h04, 30'h0000_0019, 30'h0000_0064, 1, 1, 0, "mismclr");
    // R6 timeout with no lock
    doReprog(9'h096, 3'd1, 8'h04, 30'h0000_0032, 30'h0000_0064, 1, 0, 0, "timeout");

    // R10 unprepare clears only power
    base = logN; expN = 0; bc[0] = 0; push(0, bc, 10);
    issue(2); waitEnd();
    check(endDone, "R10", "unprepare done", endDone, 1);
    compareLog(base, "unprep");

    // R9 prepare from power-down
    base = logN; expN = 0;
    bc[2] = 1; push(0, bc, 9);
    bc[0] = 1; push(0, bc, 9);
    bc[1] = 1; push(0, bc, 9);
    bc[2] = 0; push(0, bc, 9);
    issue(1); waitEnd();
    check(endDone, "R9", "prepare done", endDone, 1);
    compareLog(base, "prep");

    // R9 prepare with power already on: no writes
    base = logN; expN = 0;
    issue(1); waitEnd();
    check(endDone, "R9", "prepare no-op done", endDone, 1);
    check(logN == base, "R9", "prepare no-op writes", logN - base, 0);

    // R11 priority: start and prepare together runs the reprogram
    cfgMul = 9'h07B; cfgRef = 3'd2; cfgPost = 8'h0A; cfgNum = 30'h54; cfgDen = 30'h64; fracMode = 1;
    base = logN;
    buildReprog(9'h07B, 3'd2, 8'h0A, 30'h54, 30'h64, 1, 1);
    issue(3); waitEnd();
    check(endDone, "R11", "priority done", endDone, 1);
    compareLog(base, "prio");

    // R11 commands and config changes while busy are ignored
    cfgMul = 9'h0C9; cfgRef = 3'd4; cfgPost = 8'h14; cfgNum = 30'h248; cfgDen = 30'h3E8; fracMode = 1;
    base = logN;
    buildReprog(9'h0C9, 3'd4, 8'h14, 30'h248, 30'h3E8, 1, 1);
    fork
      begin issue(0); waitEnd(); end
      begin
        repeat (4) @(negedge clk);
        cfgMul = 9'h011; cfgPost = 8'h22; fracMode = 0;
        startReq = 1; unprepReq = 1;
        @(negedge clk);
        startReq = 0; unprepReq = 0;
        repeat (14) @(negedge clk);
        prepReq = 1;
        @(negedge clk);
        prepReq = 0;
      end
    join
    check(endDone, "R11", "busy-ignore done", endDone, 1);
    compareLog(base, "busyign");
    repeat (3) @(negedge clk);
    check(logN - base == expN && !busy, "R11", "no late command", logN - base, expN);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule